// File: doc/BRIEF.md
# PLL Lock Detector with Lock and Unlock Interrupts

This block decides whether a phase-locked loop is in lock by watching two single-cycle strobes. Both strobes are synchronous to the block clock. `pfd_tick` marks each phase-detector comparison. `slip` marks a detected cycle slip. The lock window is 2^N comparisons, where N comes from a programmable window-select field.

While out of lock, the block counts comparisons since the last slip and declares lock once the count fills the window. While in lock, it tolerates one isolated slip. It drops lock only when a second slip follows the first inside one window.

The block drives a lock flag and its inverse. Every lock gain and every lock loss sets a sticky event flag. Each flag has an enable that gates a combined interrupt output. A single control word, written through a write strobe, carries the enables, the write-one-to-clear bits and the window select.

The control state machine has three states:
- `ST_HUNT`: out of lock and counting.
- `ST_LOCKED`: in lock with no slip pending.
- `ST_WATCH`: in lock with one slip pending.

It has these transitions:
- HUNT to HUNT on a slip, which restarts the count.
- HUNT to LOCKED when the window fills.
- LOCKED to WATCH on the first slip.
- WATCH to LOCKED when the window expires, which forgets the pending slip.
- WATCH to HUNT on a second slip.

Top module: `pll_lock_monitor`

## Requirements
- R1: From reset or from the most recent slip, `locked` rises on the clock edge that samples the 2^N-th `pfd_tick`, provided no slip arrived in between. Cycles without `pfd_tick` do not advance the count.
- R2: While out of lock, a slip restarts the count from zero. A slip and a `pfd_tick` in the same cycle count as a slip only.
- R3: In lock, a single slip leaves `locked` high. A second slip before 2^N further ticks drops `locked` on that edge. If 2^N ticks pass after the first slip, that slip is forgotten.
- R4: The window select N sits in `wr_data[7:4]` and resets to 8. With that reset value, lock needs 256 ticks.
- R5: `locked` resets to 0. `locked_n` is always the inverse of `locked`.
- R6: `lock_flag` sets on the edge where `locked` rises. `unlock_flag` sets on the edge where `locked` falls. Each flag sets whether or not its enable is on. Both flags reset to 0.
- R7: Writing 1 to `wr_data[2]` clears `lock_flag`, and writing 1 to `wr_data[3]` clears `unlock_flag`. If a set event and a clear hit the same flag in the same cycle, the flag stays set.
- R8: `irq` is high when an enabled flag is set. The enable for `lock_flag` is `wr_data[0]` and the enable for `unlock_flag` is `wr_data[1]`. Both enables reset to 0.
- R9: A change to the window select leaves `locked` unchanged on the write cycle. The new window applies at the next tick comparison, so a count already at or past the new limit locks on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfd_tick | input | 1 | One phase-detector comparison this cycle |
| slip | input | 1 | Cycle slip detected this cycle |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word: [0] lock enable, [1] unlock enable, [2] clear lock flag, [3] clear unlock flag, [7:4] window select |
| locked | output | 1 | Lock indication |
| locked_n | output | 1 | Inverse of `locked` |
| lock_flag | output | 1 | Sticky lock-gained event |
| unlock_flag | output | 1 | Sticky lock-lost event |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The bench builds the block with its default parameters: a 4-bit window select and a 16-bit counter. It programs short windows at run time, and those windows bring the slip-restart, single-slip tolerance, window expiry and double-slip cases within a few dozen cycles. Separate directed runs cover the 256-tick reset window, a window shrunk below the running count, and a clear write that collides with a set event.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_LOCKED = 2'd1,
        ST_WATCH  = 2'd2
    } lock_state_e;

    localparam int CFG_LOCK_IE    = 0;
    localparam int CFG_UNLOCK_IE  = 1;
    localparam int CFG_CLR_LOCK   = 2;
    localparam int CFG_CLR_UNLOCK = 3;
    localparam int CFG_SEL_LSB    = 4;

endpackage

// File: rtl/pll_lock_cfg.sv
module pll_lock_cfg
    import pll_lock_pkg::*;
#(
    parameter int SEL_W   = 4,
    parameter int RST_SEL = 8,
    localparam int CFG_W  = CFG_SEL_LSB + SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic             lock_ie,
    output logic             unlock_ie,
    output logic [SEL_W-1:0] win_sel,
    output logic             clr_lock,
    output logic             clr_unlock
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_ie   <= 1'b0;
            unlock_ie <= 1'b0;
            win_sel   <= SEL_W'(RST_SEL);
        end else if (wr_en) begin
            lock_ie   <= wr_data[CFG_LOCK_IE];
            unlock_ie <= wr_data[CFG_UNLOCK_IE];
            win_sel   <= wr_data[CFG_W-1:CFG_SEL_LSB];
        end
    end

    always_comb begin
        clr_lock   = wr_en & wr_data[CFG_CLR_LOCK];
        clr_unlock = wr_en & wr_data[CFG_CLR_UNLOCK];
    end

endmodule

// File: rtl/pll_lock_fsm.sv
module pll_lock_fsm
    import pll_lock_pkg::*;
#(
    parameter int SEL_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pfd_tick,
    input  logic             slip,
    input  logic [SEL_W-1:0] win_sel,
    output logic             locked,
    output logic             rise_evt,
    output logic             fall_evt
);

    lock_state_e      state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [CNT_W:0]   limit, cnt_inc;
    logic             full;

    always_comb begin
        limit   = {{CNT_W{1'b0}}, 1'b1} << win_sel;
        cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
        full    = (cnt_inc >= limit);
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_HUNT: begin
                if (slip) begin
                    cnt_nx = '0;
                end else if (pfd_tick) begin
                    if (full) begin
                        state_nx = ST_LOCKED;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            ST_LOCKED: begin
                if (slip) begin
                    state_nx = ST_WATCH;
                    cnt_nx   = '0;
                end
            end
            ST_WATCH: begin
                if (slip) begin
                    state_nx = ST_HUNT;
                    cnt_nx   = '0;
                end else if (pfd_tick) begin
                    if (full) begin
                        state_nx = ST_LOCKED;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            default: begin
                state_nx = ST_HUNT;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        locked   = (state != ST_HUNT);
        rise_evt = (state == ST_HUNT) && (state_nx != ST_HUNT);
        fall_evt = (state != ST_HUNT) && (state_nx == ST_HUNT);
    end

    AST_LOCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_HUNT && $past(state) == ST_HUNT) |-> ($past(pfd_tick) && !$past(slip))); // R1
    AST_HUNT_SLIP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_HUNT && $past(slip)) |-> (state == ST_HUNT && cnt == '0)); // R2
    AST_ONE_SLIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_LOCKED) |-> (state != ST_HUNT)); // R3
    AST_DROP_NEEDS_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_HUNT && state == ST_HUNT) |-> $past(slip)); // R3

endmodule

// File: rtl/pll_lock_irq.sv
module pll_lock_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_set,
    input  logic unlock_set,
    input  logic clr_lock,
    input  logic clr_unlock,
    input  logic lock_ie,
    input  logic unlock_ie,
    output logic lock_flag,
    output logic unlock_flag,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_flag   <= 1'b0;
            unlock_flag <= 1'b0;
        end else begin
            if (lock_set)        lock_flag <= 1'b1;
            else if (clr_lock)   lock_flag <= 1'b0;
            if (unlock_set)      unlock_flag <= 1'b1;
            else if (clr_unlock) unlock_flag <= 1'b0;
        end
    end

    always_comb begin
        irq = (lock_flag & lock_ie) | (unlock_flag & unlock_ie);
    end

    AST_LOCK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_set) |-> lock_flag); // R7
    AST_UNLOCK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(unlock_set) |-> unlock_flag); // R7
    AST_LOCK_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(lock_set)); // R6
    AST_UNLOCK_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock_flag) |-> $past(unlock_set)); // R6

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
    import pll_lock_pkg::*;
#(
    parameter int SEL_W   = 4,
    parameter int RST_SEL = 8,
    localparam int CNT_W  = 1 << SEL_W,
    localparam int CFG_W  = CFG_SEL_LSB + SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pfd_tick,
    input  logic             slip,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic             locked,
    output logic             locked_n,
    output logic             lock_flag,
    output logic             unlock_flag,
    output logic             irq
);

    logic             lock_ie, unlock_ie, clr_lock, clr_unlock;
    logic             rise_evt, fall_evt;
    logic [SEL_W-1:0] win_sel;

    pll_lock_cfg #(.SEL_W(SEL_W), .RST_SEL(RST_SEL)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .lock_ie    (lock_ie),
        .unlock_ie  (unlock_ie),
        .win_sel    (win_sel),
        .clr_lock   (clr_lock),
        .clr_unlock (clr_unlock)
    );

    pll_lock_fsm #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pfd_tick (pfd_tick),
        .slip     (slip),
        .win_sel  (win_sel),
        .locked   (locked),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    pll_lock_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_set    (rise_evt),
        .unlock_set  (fall_evt),
        .clr_lock    (clr_lock),
        .clr_unlock  (clr_unlock),
        .lock_ie     (lock_ie),
        .unlock_ie   (unlock_ie),
        .lock_flag   (lock_flag),
        .unlock_flag (unlock_flag),
        .irq         (irq)
    );

    assign locked_n = ~locked;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_ie && !unlock_ie) |-> !irq); // R8
    AST_WRITE_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && !$past(pfd_tick) && !$past(slip)) |-> $stable(locked)); // R9

endmodule

// File: tb/pll_lock_monitor_bench.sv
module pll_lock_monitor_bench;

    localparam int PERIOD   = 10;
    localparam int WATCHDOG = 100000;
    localparam int NVEC     = 24;
    // each vector: {pfd_tick, slip, expected locked}, window select 2 (4 ticks)
    localparam logic [2:0] VEC [NVEC] = '{
        3'b100, 3'b100, 3'b010, 3'b100, 3'b100, 3'b100, 3'b110, 3'b100,
        3'b000, 3'b100, 3'b100, 3'b101, 3'b011, 3'b101, 3'b101, 3'b101,
        3'b101, 3'b011, 3'b101, 3'b010, 3'b100, 3'b100, 3'b100, 3'b101
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pfd_tick = 1'b0;
    logic       slip = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       locked, locked_n, lock_flag, unlock_flag, irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(PERIOD/2) clk = ~clk;

    pll_lock_monitor u_pll_lock_monitor (
        .clk         (clk),
        .rst_n       (rst_n),
        .pfd_tick    (pfd_tick),
        .slip        (slip),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .locked      (locked),
        .locked_n    (locked_n),
        .lock_flag   (lock_flag),
        .unlock_flag (unlock_flag),
        .irq         (irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic s, input logic w, input logic [7:0] d);
        @(negedge clk);
        pfd_tick = t;
        slip     = s;
        wr_en    = w;
        wr_data  = d;
        @(posedge clk);
        #(PERIOD/4);
        pfd_tick = 1'b0;
        slip     = 1'b0;
        wr_en    = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R5 / R6 / R8 reset state
        check("R5 locked reset", locked, 1'b0);
        check("R5 locked_n reset", locked_n, 1'b1);
        check("R6 lock_flag reset", lock_flag, 1'b0);
        check("R6 unlock_flag reset", unlock_flag, 1'b0);
        check("R8 irq reset", irq, 1'b0);

        // R4 default window of 256 ticks
        for (int i = 0; i < 255; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
        check("R4 255 ticks unlocked", locked, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 8'h00);
        check("R4 256th tick locks", locked, 1'b1);
        check("R5 locked_n inverse", locked_n, 1'b0);
        check("R6 lock_flag sets with enable off", lock_flag, 1'b1);
        check("R8 irq gated by enable", irq, 1'b0);

        // R8 enable raises irq; R7 clear drops it
        cyc(1'b0, 1'b0, 1'b1, 8'h81);
        check("R8 irq with lock enable", irq, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 8'h85);
        check("R7 lock_flag cleared", lock_flag, 1'b0);
        check("R8 irq after clear", irq, 1'b0);

        // vector table with window select 2
        do_reset();
        cyc(1'b0, 1'b0, 1'b1, 8'h20);
        for (int v = 0; v < NVEC; v++) begin
            cyc(VEC[v][2], VEC[v][1], 1'b0, 8'h00);
            // R1 R2 R3 sequence
            check($sformatf("R1/R2/R3 vector %0d locked", v), locked, VEC[v][0]);
            check($sformatf("R5 vector %0d locked_n", v), locked_n, ~VEC[v][0]);
        end
        check("R6 lock_flag after table", lock_flag, 1'b1);
        check("R6 unlock_flag after table", unlock_flag, 1'b1);
        check("R8 irq enables off", irq, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 8'h22);
        check("R8 irq with unlock enable", irq, 1'b1);

        // R7 set wins over same-cycle clear
        cyc(1'b0, 1'b0, 1'b1, 8'h28);
        check("R7 unlock_flag cleared", unlock_flag, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        check("R3 first slip keeps lock", locked, 1'b1);
        cyc(1'b0, 1'b1, 1'b1, 8'h28);
        check("R3 second slip drops lock", locked, 1'b0);
        check("R7 set wins over clear", unlock_flag, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 8'h28);
        check("R7 clear alone", unlock_flag, 1'b0);

        // R9 shrink window below running count
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
        check("R9 three ticks unlocked", locked, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 8'h10);
        check("R9 write does not lock", locked, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 8'h00);
        check("R9 next tick locks", locked, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 8'hF0);
        check("R9 widen keeps lock", locked, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule